// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs read and write cycles on an external memory bus on behalf of one internal 16-bit requester. The requester raises `req` with an address, write data, a write flag and two byte enables, then holds them until `ack` pulses. For reads, `rdata` is valid during that pulse. The bus configuration inputs are sampled once, in the cycle a request is accepted. That lets each access pick its own settings:

- multiplexed or separate address/data pins;
- an 8-bit or 16-bit data width;
- the length of the address latch pulse;
- an optional strobe delay;
- wait states;
- read recovery time;
- whether a ready input is used, and which level of it counts as active.

On the external side the block produces:

- an address latch strobe (`bus_ale`);
- active-low read and write strobes;
- a dedicated address port;
- active-low byte enables;
- a shared data port, with one output enable per byte lane.

In the multiplexed modes the shared port carries the low 16 address bits while the latch strobe is high. After that phase it carries data. In the 8-bit modes only the low byte lane of the port carries data. A 16-bit access in an 8-bit mode is split into two byte cycles, low byte first. A single-chip setting turns every request into an immediate acknowledge with no bus activity. Byte enable bit 0 selects the even byte, which is `data[7:0]`. Bit 1 selects the odd byte, which is `data[15:8]`.

Top module: `ext_bus_seq`

## Requirements
- R1: When `cfg_single` is 1 at acceptance, `ack` pulses in the cycle after acceptance. No latch strobe and no read or write strobe appears, and `rdata` reads 0.
- R2: Each byte cycle begins with `bus_ale` high for 1+`cfg_ale` cycles. The byte address is on `bus_addr` during that time. In a multiplexed mode, `bus_dout` also equals `bus_addr[15:0]` then, with `bus_oe` = 2'b11.
- R3: When `cfg_strb_dly` is 1, exactly one idle cycle separates the fall of `bus_ale` from the start of the strobe. When it is 0, the strobe starts in the first cycle after `bus_ale` falls.
- R4: When `cfg_rdy_en` is 0, the read or write strobe stays low for exactly 1+`cfg_wait` cycles, and `bus_ready` has no effect.
- R5: When `cfg_rdy_en` is 1, `bus_ready` passes through a two-flop synchronizer. It is looked at only after the wait cycles have elapsed. The strobe ends at the first such cycle in which the synchronized value equals `cfg_rdy_pol` (1 = active high, 0 = active low).
- R6: In the 16-bit modes, `bus_be_n` equals ~`be` while a cycle is in progress. A write drives `wdata` on the whole data port. A read returns `bus_din` with the lanes whose enable is 0 forced to zero.
- R7: In the 8-bit modes, data uses `bus_dout[7:0]`, `bus_din[7:0]` and `bus_oe[0]` only, and `bus_addr[0]` gives the byte. `be` = 2'b11 runs two byte cycles, at the even byte and then the odd byte, and the two read bytes are reassembled into `rdata`. `be` = 2'b01 or 2'b10 runs a single cycle at the even or odd byte.
- R8: `bus_oe` is 2'b00 while the read strobe is low, in every mode. In a multiplexed write, the data port switches from address to write data once `bus_ale` falls.
- R9: After every read strobe, for `cfg_tri` cycles, `bus_oe` stays 2'b00 and `bus_ale` stays low.
- R10: `ack` is a one-cycle pulse. Counting the accepting clock edge as 1, `ack` is seen after 1 + N×((1+`cfg_ale`) + `cfg_strb_dly` + S + T) edges. Here N is the number of byte cycles, S is the strobe length, and T is `cfg_tri` for reads and 0 for writes. After reset, `ack` is 0.
- R11: The read and write strobes are never low together, and neither is low while `bus_ale` is high. After reset both strobes are high and `bus_oe` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_single | input | 1 | Single-chip setting: no external cycle |
| cfg_mux | input | 1 | 1 = address and data share the data port |
| cfg_bus8 | input | 1 | 1 = 8-bit external data width |
| cfg_strb_dly | input | 1 | Adds one cycle before the strobe |
| cfg_rdy_en | input | 1 | Enables ready stretching |
| cfg_rdy_pol | input | 1 | Active level of the ready input |
| cfg_wait | input | WAITW | Wait cycles added to the strobe |
| cfg_tri | input | TRIW | Recovery cycles after a read |
| cfg_ale | input | ALEW | Extra latch-strobe cycles |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address, bit 0 zero |
| wdata | input | 16 | Write data |
| be | input | 2 | Byte enables, bit 0 = even byte |
| ack | output | 1 | Completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Dedicated address port |
| bus_be_n | output | 2 | Byte enables, active low |
| bus_dout | output | 16 | Shared data port, driven value |
| bus_oe | output | 2 | Output enable per byte lane |
| bus_din | input | 16 | Shared data port, received value |
| bus_ready | input | 1 | Asynchronous ready input |

## Verification
The bench uses a byte-addressed memory model that answers the strobes. It mixes directed accesses with random ones, drawing each access's mode, width, byte enables, delays and ready polarity at random. Directed cases cover the single-chip setting and a two-byte 8-bit read with the longest recovery. They also cover the longest wait with a delayed strobe and ready pulses of both polarities.

Running the same byte enables across multiplexed and demultiplexed modes separates address-phase faults from data-phase faults. Running them across 8-bit and 16-bit widths exposes faults in the byte split and reassembly. Ready pulses are placed at several distances past the wait count, so the measured strobe length shows both the synchronizer depth and the wait-before-ready rule. While ready is disabled, `bus_ready` is toggled at random to show that it is ignored.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int AW    = 24,
  parameter int WAITW = 4,
  parameter int TRIW  = 2,
  parameter int ALEW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_single,
  input  logic             cfg_mux,
  input  logic             cfg_bus8,
  input  logic             cfg_strb_dly,
  input  logic             cfg_rdy_en,
  input  logic             cfg_rdy_pol,
  input  logic [WAITW-1:0] cfg_wait,
  input  logic [TRIW-1:0]  cfg_tri,
  input  logic [ALEW-1:0]  cfg_ale,
  input  logic             req,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [15:0]      wdata,
  input  logic [1:0]       be,
  output logic             ack,
  output logic [15:0]      rdata,
  output logic             bus_ale,
  output logic             bus_rd_n,
  output logic             bus_wr_n,
  output logic [AW-1:0]    bus_addr,
  output logic [1:0]       bus_be_n,
  output logic [15:0]      bus_dout,
  output logic [1:0]       bus_oe,
  input  logic [15:0]      bus_din,
  input  logic             bus_ready
);

  localparam int CW0 = (WAITW > TRIW) ? WAITW : TRIW;
  localparam int CW  = (CW0 > ALEW) ? CW0 : ALEW;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DLY, S_STRB, S_REC, S_ACK} state_t;

  state_t            st;
  logic [CW-1:0]     cnt;
  logic              m_mux, m_bus8, m_dly, m_ren, m_pol, m_we;
  logic [WAITW-1:0]  m_wait;
  logic [TRIW-1:0]   m_tri;
  logic [ALEW-1:0]   m_ale;
  logic [AW-1:0]     a_q;
  logic [15:0]       wd_q, rd_q;
  logic [1:0]        be_q;
  logic              lane, more;
  logic              rs1, rs2;

  wire rdy_ok   = !m_ren || (rs2 == m_pol);
  wire strb     = (st == S_STRB);
  wire in_cycle = (st == S_ADDR) || (st == S_DLY) || strb;
  wire addr_ph  = (st == S_ADDR) && m_mux;
  wire data_ph  = m_we && (strb || st == S_DLY || (st == S_ADDR && !m_mux));
  wire [7:0]  byte_wd   = lane ? wd_q[15:8] : wd_q[7:0];
  wire [15:0] data_word = m_bus8 ? {8'h00, byte_wd} : wd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      {m_mux, m_bus8, m_dly, m_ren, m_pol, m_we} <= '0;
      m_wait <= '0;
      m_tri <= '0;
      m_ale <= '0;
      a_q <= '0;
      wd_q <= '0;
      rd_q <= '0;
      be_q <= '0;
      lane <= 1'b0;
      more <= 1'b0;
      rs1 <= 1'b0;
      rs2 <= 1'b0;
    end else begin
      rs1 <= bus_ready;
      rs2 <= rs1;
      case (st)
        S_IDLE: if (req) begin
          m_mux  <= cfg_mux;
          m_bus8 <= cfg_bus8;
          m_dly  <= cfg_strb_dly;
          m_ren  <= cfg_rdy_en;
          m_pol  <= cfg_rdy_pol;
          m_wait <= cfg_wait;
          m_tri  <= cfg_tri;
          m_ale  <= cfg_ale;
          m_we   <= we;
          a_q    <= addr;
          wd_q   <= wdata;
          be_q   <= be;
          rd_q   <= '0;
          lane   <= cfg_bus8 && (be == 2'b10);
          more   <= cfg_bus8 && (be == 2'b11);
          cnt    <= CW'(cfg_ale);
          st     <= cfg_single ? S_ACK : S_ADDR;
        end
        S_ADDR: if (cnt != '0) cnt <= cnt - CW'(1);
                else begin
                  cnt <= CW'(m_wait);
                  st  <= m_dly ? S_DLY : S_STRB;
                end
        S_DLY: st <= S_STRB;
        S_STRB: if (cnt != '0) cnt <= cnt - CW'(1);
                else if (rdy_ok) begin
                  if (!m_we) begin
                    if (!m_bus8)   rd_q <= bus_din & {{8{be_q[1]}}, {8{be_q[0]}}};
                    else if (lane) rd_q[15:8] <= bus_din[7:0];
                    else           rd_q[7:0]  <= bus_din[7:0];
                  end
                  if (!m_we && m_tri != '0) begin
                    cnt <= CW'(m_tri) - CW'(1);
                    st  <= S_REC;
                  end else if (more) begin
                    st   <= S_ADDR;
                    lane <= 1'b1;
                    more <= 1'b0;
                    cnt  <= CW'(m_ale);
                  end else st <= S_ACK;
                end
        S_REC: if (cnt != '0) cnt <= cnt - CW'(1);
               else if (more) begin
                 st   <= S_ADDR;
                 lane <= 1'b1;
                 more <= 1'b0;
                 cnt  <= CW'(m_ale);
               end else st <= S_ACK;
        S_ACK: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ack      = (st == S_ACK);
  assign rdata    = rd_q;
  assign bus_ale  = (st == S_ADDR);
  assign bus_rd_n = !(strb && !m_we);
  assign bus_wr_n = !(strb && m_we);
  assign bus_addr = {a_q[AW-1:1], m_bus8 ? lane : a_q[0]};
  assign bus_be_n = !in_cycle ? 2'b11 : (m_bus8 ? 2'b10 : ~be_q);
  assign bus_dout = addr_ph ? bus_addr[15:0] : data_word;
  assign bus_oe   = addr_ph ? 2'b11 : (data_ph ? (m_bus8 ? 2'b01 : 2'b11) : 2'b00);

  assert_strb_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_n || bus_wr_n) && !(bus_ale && !(bus_rd_n && bus_wr_n)));

  assert_rd_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> bus_oe == 2'b00);

  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && cfg_single) |=> (ack && !bus_ale));

  assert_rdy_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ren && ($rose(bus_rd_n) || $rose(bus_wr_n))) |-> $past(rs2) == m_pol);

  assert_recover_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) && m_tri != '0) |-> (bus_oe == 2'b00 && !bus_ale));

endmodule

// File: tb/test_ext_bus_seq.sv
module test_ext_bus_seq;
  localparam int AW = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_single = 0, cfg_mux = 0, cfg_bus8 = 0, cfg_strb_dly = 0, cfg_rdy_en = 0, cfg_rdy_pol = 0;
  logic [3:0] cfg_wait = 0;
  logic [1:0] cfg_tri = 0, cfg_ale = 0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = 0;
  logic [15:0] wdata = 0, rdata, bus_dout, bus_din = 0;
  logic [1:0] be = 0, bus_be_n, bus_oe;
  logic ack, bus_ale, bus_rd_n, bus_wr_n, bus_ready = 0;
  logic [AW-1:0] bus_addr;

  ext_bus_seq #(.AW(AW), .WAITW(4), .TRIW(2), .ALEW(2)) i_ext_bus_seq (
    .clk, .rst_n, .cfg_single, .cfg_mux, .cfg_bus8, .cfg_strb_dly, .cfg_rdy_en, .cfg_rdy_pol,
    .cfg_wait, .cfg_tri, .cfg_ale, .req, .we, .addr, .wdata, .be, .ack, .rdata,
    .bus_ale, .bus_rd_n, .bus_wr_n, .bus_addr, .bus_be_n, .bus_dout, .bus_oe, .bus_din, .bus_ready);

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mem [256];
  int e_ale, e_dly, e_slen, e_tri, e_r;
  bit e_mux, e_bus8, e_ren, e_pol;
  int nb, ale_run, gap, scnt, post_rd;
  int bad_ale, bad_dly, bad_strb, bad_oe, bad_rec, bad_mux, bad_excl;
  bit prev_ale, prev_rd, in_gap;
  logic [AW-1:0] seen_addr [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int exp_latency(bit single, int nbc, int al, int dly, int s, int tr, bit w);
    if (single) return 1;
    return 1 + nbc * ((1 + al) + dly + s + (w ? 0 : tr));
  endfunction

  function automatic logic [15:0] exp_word(logic [15:0] oldw, logic [15:0] neww, logic [1:0] bev);
    return {bev[1] ? neww[15:8] : oldw[15:8], bev[0] ? neww[7:0] : oldw[7:0]};
  endfunction

  // bus monitor and memory model
  initial begin
    forever begin
      @(negedge clk);
      if (!bus_rd_n && !bus_wr_n || bus_ale && (!bus_rd_n || !bus_wr_n)) bad_excl++;
      if (bus_ale) begin
        if (!prev_ale) begin
          if (nb < 2) seen_addr[nb] = bus_addr;
          nb++;
        end
        ale_run++;
        if (e_mux && (bus_oe != 2'b11 || bus_dout != bus_addr[15:0])) bad_mux++;
      end else if (prev_ale) begin
        if (ale_run != e_ale) bad_ale++;
        ale_run = 0;
        gap = 0;
        in_gap = 1;
      end
      if (in_gap) begin
        if (!bus_rd_n || !bus_wr_n) begin
          if (gap != e_dly) bad_dly++;
          in_gap = 0;
        end else gap++;
      end
      if (prev_rd && bus_rd_n) post_rd = e_tri;
      if (post_rd > 0) begin
        if (bus_oe != 2'b00 || bus_ale) bad_rec++;
        post_rd--;
      end
      if (!bus_rd_n || !bus_wr_n) begin
        scnt++;
        if (!bus_rd_n && bus_oe != 2'b00) bad_oe++;
        if (e_ren) bus_ready = (scnt == e_r) ? e_pol : !e_pol;
        else bus_ready = 1'($urandom);
        if (!bus_rd_n) begin
          if (e_bus8) bus_din = {8'($urandom), mem[bus_addr[7:0]]};
          else bus_din = {mem[{bus_addr[7:1], 1'b1}], mem[{bus_addr[7:1], 1'b0}]};
        end else begin
          if (e_bus8) begin
            if (bus_oe[0]) mem[bus_addr[7:0]] = bus_dout[7:0];
          end else begin
            if (!bus_be_n[0]) mem[{bus_addr[7:1], 1'b0}] = bus_dout[7:0];
            if (!bus_be_n[1]) mem[{bus_addr[7:1], 1'b1}] = bus_dout[15:8];
          end
        end
      end else begin
        if (scnt != 0) begin
          if (scnt != e_slen) bad_strb++;
          scnt = 0;
        end
        bus_ready = e_ren ? !e_pol : 1'($urandom);
        bus_din = 16'($urandom);
      end
      prev_ale = bus_ale;
      prev_rd = !bus_rd_n;
    end
  end

  task automatic run(input bit single, mux, b8, dly, ren, pol, input int wt, tr, al, r,
                     input bit w, input logic [AW-1:0] ad, input logic [15:0] wd, input logic [1:0] bev);
    int n, enb, s, el;
    logic [15:0] oldw, got, expw;
    logic [7:0] a;
    cfg_single = single; cfg_mux = mux; cfg_bus8 = b8; cfg_strb_dly = dly;
    cfg_rdy_en = ren; cfg_rdy_pol = pol; cfg_wait = 4'(wt); cfg_tri = 2'(tr); cfg_ale = 2'(al);
    e_mux = mux; e_bus8 = b8; e_ren = ren; e_pol = pol; e_ale = 1 + al; e_dly = dly;
    e_tri = tr; e_r = r;
    s = ren ? r + 2 : 1 + wt;
    e_slen = s;
    repeat (3) @(negedge clk);
    nb = 0; bad_ale = 0; bad_dly = 0; bad_strb = 0; bad_oe = 0; bad_rec = 0; bad_mux = 0; bad_excl = 0;
    a = {ad[7:1], 1'b0};
    oldw = {mem[a + 8'd1], mem[a]};
    req = 1; we = w; addr = ad; wdata = wd; be = bev;
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!ack && n < 2000);
    got = rdata;
    req = 0;
    @(negedge clk);
    enb = single ? 0 : ((b8 && bev == 2'b11) ? 2 : 1);
    el = exp_latency(single, enb, al, dly, s, tr, w);
    chk(n == el, "R10", n, el);
    if (single) begin
      chk(nb == 0 && got == 16'h0, "R1", {nb[15:0], got}, 0);
    end else begin
      chk(nb == enb, "R7", nb, enb);
      chk(bad_ale == 0, "R2", bad_ale, 0);
      chk(seen_addr[0] == (b8 ? {ad[AW-1:1], bev == 2'b10} : ad), "R2", seen_addr[0],
          b8 ? {ad[AW-1:1], bev == 2'b10} : ad);
      if (enb == 2) chk(seen_addr[1] == {ad[AW-1:1], 1'b1}, "R7", seen_addr[1], {ad[AW-1:1], 1'b1});
      if (mux) chk(bad_mux == 0, "R8", bad_mux, 0);
      chk(bad_dly == 0, "R3", bad_dly, 0);
      if (ren) chk(bad_strb == 0, "R5", bad_strb, 0);
      else chk(bad_strb == 0, "R4", bad_strb, 0);
      chk(bad_oe == 0, "R8", bad_oe, 0);
      chk(bad_rec == 0, "R9", bad_rec, 0);
      chk(bad_excl == 0, "R11", bad_excl, 0);
      if (!w) begin
        expw = exp_word(16'h0, oldw, bev);
        chk(got == expw, b8 ? "R7" : "R6", got, expw);
      end else begin
        expw = exp_word(oldw, wd, bev);
        chk({mem[a + 8'd1], mem[a]} == expw, b8 ? "R7" : "R6", {mem[a + 8'd1], mem[a]}, expw);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ack == 0, "R10", ack, 0);
    chk(bus_rd_n && bus_wr_n && !bus_ale && bus_oe == 2'b00, "R11",
        {bus_rd_n, bus_wr_n, bus_ale, bus_oe}, 5'b11000);
    // directed corners
    run(1, 0, 0, 0, 0, 0, 3, 1, 1, 0, 0, 24'h12_3450, 16'h0, 2'b11);
    run(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 24'hA0_0010, 16'h0, 2'b11);
    run(0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 24'h00_4422, 16'hBEEF, 2'b11);
    run(0, 1, 1, 0, 0, 0, 2, 3, 1, 0, 0, 24'h00_4422, 16'h0, 2'b11);
    run(0, 1, 0, 1, 0, 0, 15, 2, 3, 0, 1, 24'h7F_00FE, 16'h5A5A, 2'b10);
    run(0, 0, 0, 0, 1, 1, 2, 1, 0, 4, 0, 24'h01_0040, 16'h0, 2'b01);
    run(0, 1, 1, 1, 1, 0, 0, 2, 0, 1, 0, 24'h02_0080, 16'h0, 2'b11);
    run(0, 0, 1, 0, 1, 0, 5, 0, 2, 8, 1, 24'h03_00C6, 16'h1234, 2'b10);
    // constrained random
    for (int k = 0; k < 200; k++) begin
      int wt, rr;
      logic [1:0] bev;
      wt = int'($urandom_range(0, 15));
      rr = (wt < 1 ? 1 : wt) + int'($urandom_range(0, 3));
      bev = 2'($urandom_range(1, 3));
      run(($urandom_range(0, 15) == 0), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), wt, int'($urandom_range(0, 3)),
          int'($urandom_range(0, 3)), rr, 1'($urandom),
          {16'($urandom), 7'($urandom), 1'b0}, 16'($urandom), bev);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule